// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Controller

This block is the digital front end of a two-channel 13-bit digital-to-analog converter. A host writes 16-bit command words over a three-wire serial port made of an active-low select, a serial clock and a data line. The port pins are brought into the system clock domain through a synchronizer bank. Bits are shifted in on serial clock rising edges while the select is low. When the select is released, the word is decoded and executed.

Each channel is double buffered. A staging register takes new data, and a live code register drives the converter. Commands can load the staging registers, copy them into the live registers one channel at a time or both together, or write both live registers directly. Other commands put either channel to sleep, set a general-purpose output pin, or choose which serial clock edge drives the daisy-chain output.

Sleep only takes effect while the shutdown-enable input is high. When that input is pulled low, every sleeping channel wakes at once, without waiting for a clock. An active-low clear input returns the whole block to its power-up state.

Top module: `dacser_ctrl`

## Requirements
- R1: A word is 16 bits, sent most significant bit first. Bits 15:13 are the opcode and bits 12:0 are the data. Bits are taken on serial clock rising edges while `cs_n` is low, and the word executes when `cs_n` rises, using the last 16 bits shifted in.
- R2: Opcode 001 writes the data into the staging register of channel A, and opcode 101 writes it into channel B. Neither live code changes.
- R3: Opcode 010 (channel A) or 110 (channel B) writes the data into that staging register. Both live codes are then loaded from their staging registers, including the new value.
- R4: Opcode 011 writes the data into both live codes and leaves both staging registers unchanged.
- R5: Opcode 100 copies both staging registers into the live codes. With opcode 000, a subcommand in bits 12:10 of 001 copies channel A only, and 101 copies channel B only.
- R6: Opcode 111 puts both channels to sleep. Opcode 000 with subcommand 110 puts channel A to sleep, and subcommand 111 puts channel B to sleep. Each takes effect only while `sd_enable` is high, and the live codes are kept.
- R7: While `sd_enable` is low, sleep commands have no effect. When `sd_enable` falls, sleeping channels wake immediately, without waiting for a clock.
- R8: A sleeping channel keeps accepting staging writes and stays asleep. Any command that writes its live code wakes it.
- R9: Opcode 000 with subcommand 010 drives `user_out` low, and subcommand 011 drives it high.
- R10: Opcode 000 with subcommand 100 selects the `sdo` launch edge from bit 9: 1 selects the rising edge, 0 selects the falling edge. In falling mode, `sdo` changes on the falling edge after serial rising edge k and shows the bit taken on rising edge k-15. In rising mode, it shows that same bit from rising edge k onward.
- R11: Reset, or `clr_n` low (which acts asynchronously), sets both staging registers and both live codes to zero. It also wakes both channels, drives `user_out` low and selects falling-edge `sdo`.
- R12: Serial clock edges while `cs_n` is high shift nothing. Opcode 000 with subcommand 000 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low reset |
| clr_n | input | 1 | Active-low asynchronous clear |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sd_enable | input | 1 | High allows sleep; falling edge wakes all channels |
| code_a | output | 13 | Live code, channel A |
| code_b | output | 13 | Live code, channel B |
| sleep_a | output | 1 | Channel A asleep |
| sleep_b | output | 1 | Channel B asleep |
| user_out | output | 1 | General-purpose output |
| sdo | output | 1 | Daisy-chain serial output |

## Verification
A corrupted staging register stays hidden until a copy command moves it into a live code. The bench therefore loads staging registers and then copies them in several orders, and checks the live codes about one serial frame later. A wrong decode or wrong sleep state shows at `code_*`, `sleep_*` or `user_out` within a few system clocks of `cs_n` rising. A shift-register fault shows at `sdo` on each serial edge, with the launch edge telling the two modes apart by a half serial period.

// File: rtl/dacser_pkg.sv
package dacser_pkg;

   typedef enum logic [2:0] {
      OP_MISC   = 3'b000,
      OP_STG_A  = 3'b001,
      OP_STGU_A = 3'b010,
      OP_DIRECT = 3'b011,
      OP_COPY   = 3'b100,
      OP_STG_B  = 3'b101,
      OP_STGU_B = 3'b110,
      OP_NAP    = 3'b111
   } op_e;

   typedef enum logic [2:0] {
      SUB_NONE   = 3'b000,
      SUB_COPY_A = 3'b001,
      SUB_PIN_LO = 3'b010,
      SUB_PIN_HI = 3'b011,
      SUB_EDGE   = 3'b100,
      SUB_COPY_B = 3'b101,
      SUB_NAP_A  = 3'b110,
      SUB_NAP_B  = 3'b111
   } sub_e;

   typedef struct packed {
      logic [1:0] stage;
      logic [1:0] copy;
      logic       direct;
      logic [1:0] nap;
      logic       pin_wr;
      logic       pin_val;
      logic       edge_wr;
      logic       edge_val;
   } cmd_t;

endpackage

// File: rtl/dacser_sync.sv
module dacser_sync #(
   parameter int           STAGES  = 2,
   parameter int           W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("dacser_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dacser_shift.sv
module dacser_shift #(
   parameter int WW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          rise,
   input  logic          fall,
   input  logic          din,
   input  logic          rise_mode,
   output logic [WW-1:0] word,
   output logic          sdo
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word <= '0;
      end else if (active && rise) begin
         word <= {word[WW-2:0], din};
      end
   end

   // rising mode presents the bit that becomes the top bit on this edge;
   // falling mode presents the top bit half a serial period later
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdo <= 1'b0;
      end else if (active) begin
         if (rise_mode && rise)       sdo <= word[WW-2];
         else if (!rise_mode && fall) sdo <= word[WW-1];
      end
   end
endmodule

// File: rtl/dacser_decode.sv
module dacser_decode
   import dacser_pkg::*;
(
   input  logic       exec,
   input  logic       nap_ok,
   input  logic [2:0] op,
   input  logic [2:0] sub,
   input  logic       edge_bit,
   output cmd_t       cmd
);
   always_comb begin
      cmd = '0;
      if (exec) begin
         case (op_e'(op))
            OP_STG_A:  cmd.stage = 2'b01;
            OP_STG_B:  cmd.stage = 2'b10;
            OP_STGU_A: begin cmd.stage = 2'b01; cmd.copy = 2'b11; end
            OP_STGU_B: begin cmd.stage = 2'b10; cmd.copy = 2'b11; end
            OP_DIRECT: cmd.direct = 1'b1;
            OP_COPY:   cmd.copy = 2'b11;
            OP_NAP:    cmd.nap = {2{nap_ok}};
            default: begin
               case (sub_e'(sub))
                  SUB_COPY_A: cmd.copy = 2'b01;
                  SUB_COPY_B: cmd.copy = 2'b10;
                  SUB_NAP_A:  cmd.nap  = {1'b0, nap_ok};
                  SUB_NAP_B:  cmd.nap  = {nap_ok, 1'b0};
                  SUB_PIN_LO: cmd.pin_wr = 1'b1;
                  SUB_PIN_HI: begin cmd.pin_wr = 1'b1; cmd.pin_val = 1'b1; end
                  SUB_EDGE:   begin cmd.edge_wr = 1'b1; cmd.edge_val = edge_bit; end
                  default:    cmd = '0;
               endcase
            end
         endcase
      end
   end
endmodule

// File: rtl/dacser_chan.sv
module dacser_chan #(
   parameter int DW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wake_n,
   input  logic          stage,
   input  logic          copy,
   input  logic          direct,
   input  logic          nap,
   input  logic [DW-1:0] data,
   output logic [DW-1:0] code,
   output logic          sleep
);
   logic [DW-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
         code  <= '0;
      end else begin
         if (stage)       stg_q <= data;
         if (direct)      code  <= data;
         else if (copy)   code  <= stage ? data : stg_q;
      end
   end

   always_ff @(posedge clk or negedge wake_n) begin
      if (!wake_n)              sleep <= 1'b0;
      else if (direct || copy)  sleep <= 1'b0;
      else if (nap)             sleep <= 1'b1;
   end
endmodule

// File: rtl/dacser_ctrl.sv
module dacser_ctrl
   import dacser_pkg::*;
#(
   parameter int DW          = 13,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_n,
   input  logic          cs_n,
   input  logic          sck,
   input  logic          sdi,
   input  logic          sd_enable,
   output logic [DW-1:0] code_a,
   output logic [DW-1:0] code_b,
   output logic          sleep_a,
   output logic          sleep_b,
   output logic          user_out,
   output logic          sdo
);
   localparam int WW  = DW + 3;
   localparam int NCH = 2;

   generate
      if (DW < 4) begin : g_bad_dw
         $error("dacser_ctrl: DW must leave room for subcommand and edge bits");
      end
   endgenerate

   logic rst_all_n, wake_n;
   assign rst_all_n = rst_n & clr_n;
   assign wake_n    = rst_all_n & sd_enable;

   logic lk_s, cs_s, sck_s, sdi_s;
   dacser_sync #(.STAGES(SYNC_STAGES), .W(4), .RST_VAL(4'b0100)) u_sync (
      .clk(clk), .rst_n(rst_all_n),
      .d({sd_enable, cs_n, sck, sdi}),
      .q({lk_s, cs_s, sck_s, sdi_s})
   );

   logic sck_q, cs_q;
   always_ff @(posedge clk or negedge rst_all_n) begin
      if (!rst_all_n) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b1;
      end else begin
         sck_q <= sck_s;
         cs_q  <= cs_s;
      end
   end

   logic sck_rise, sck_fall, exec_stb, rise_mode;
   assign sck_rise = sck_s & ~sck_q;
   assign sck_fall = ~sck_s & sck_q;
   assign exec_stb = cs_s & ~cs_q;

   logic [WW-1:0] word;
   dacser_shift #(.WW(WW)) u_shift (
      .clk(clk), .rst_n(rst_all_n), .active(~cs_s), .rise(sck_rise),
      .fall(sck_fall), .din(sdi_s), .rise_mode(rise_mode),
      .word(word), .sdo(sdo)
   );

   cmd_t cmd;
   dacser_decode u_dec (
      .exec(exec_stb), .nap_ok(lk_s),
      .op(word[WW-1:WW-3]), .sub(word[DW-1:DW-3]), .edge_bit(word[DW-4]),
      .cmd(cmd)
   );

   logic [NCH-1:0][DW-1:0] codes;
   logic [NCH-1:0]         sleeps;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         dacser_chan #(.DW(DW)) u_ch (
            .clk(clk), .rst_n(rst_all_n), .wake_n(wake_n),
            .stage(cmd.stage[c]), .copy(cmd.copy[c]), .direct(cmd.direct),
            .nap(cmd.nap[c]), .data(word[DW-1:0]),
            .code(codes[c]), .sleep(sleeps[c])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_all_n) begin
      if (!rst_all_n) begin
         user_out  <= 1'b0;
         rise_mode <= 1'b0;
      end else begin
         if (cmd.pin_wr)  user_out  <= cmd.pin_val;
         if (cmd.edge_wr) rise_mode <= cmd.edge_val;
      end
   end

   assign code_a  = codes[0];
   assign code_b  = codes[1];
   assign sleep_a = sleeps[0];
   assign sleep_b = sleeps[1];
endmodule

// File: rtl/dacser_ctrl_chk.sv
module dacser_ctrl_chk #(
   parameter int DW = 13
) (
   input logic          clk,
   input logic          rst_n,
   input logic          exec,
   input logic          lock,
   input logic [DW-1:0] code_a,
   input logic [DW-1:0] code_b,
   input logic          sleep_a,
   input logic          sleep_b,
   input logic          user_out
);
   // R7: no channel may be asleep while sleep is disallowed
   a_r7_lock_holds_awake: assert property (@(posedge clk) disable iff (!rst_n)
      !lock |-> (!sleep_a && !sleep_b));

   // R2: live codes move only in the cycle after a word executes
   a_r2_code_a_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !exec |=> $stable(code_a));
   a_r2_code_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !exec |=> $stable(code_b));

   // R9: the general-purpose pin changes only through a command
   a_r9_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !exec |=> $stable(user_out));

   // R6: a channel enters sleep only right after a command
   a_r6_nap_a_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_a) |-> $past(exec));
   a_r6_nap_b_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_b) |-> $past(exec));
endmodule

bind dacser_ctrl dacser_ctrl_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_all_n), .exec(exec_stb), .lock(sd_enable),
   .code_a(code_a), .code_b(code_b), .sleep_a(sleep_a), .sleep_b(sleep_b),
   .user_out(user_out)
);

// File: tb/dacser_ctrl_bench.sv
module dacser_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 13;

   logic clk = 1'b0;
   logic rst_n, clr_n, cs_n, sck, sdi, sd_enable;
   logic [DW-1:0] code_a, code_b;
   logic sleep_a, sleep_b, user_out, sdo;

   always #(CLK_PERIOD/2) clk = ~clk;

   dacser_ctrl u_dacser_ctrl (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .sck(sck),
      .sdi(sdi), .sd_enable(sd_enable), .code_a(code_a), .code_b(code_b),
      .sleep_a(sleep_a), .sleep_b(sleep_b), .user_out(user_out), .sdo(sdo)
   );

   int n_run = 0;
   int n_fail = 0;

   // expected-state model built from the requirements
   logic [DW-1:0] m_stg [2];
   logic [DW-1:0] m_code [2];
   logic          m_sl [2];
   logic          m_pin;

   logic [28:0] exp_q [$];
   string       tag_q [$];
   event        mon_ev;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic void model_reset();
      for (int c = 0; c < 2; c++) begin
         m_stg[c] = '0; m_code[c] = '0; m_sl[c] = 1'b0;
      end
      m_pin = 1'b0;
   endfunction

   function automatic void model_apply(logic [15:0] w);
      logic [2:0] op;
      logic [2:0] sub;
      logic [DW-1:0] d;
      op = w[15:13]; sub = w[12:10]; d = w[12:0];
      case (op)
         3'b001: m_stg[0] = d;
         3'b101: m_stg[1] = d;
         3'b010, 3'b110, 3'b100: begin
            if (op == 3'b010) m_stg[0] = d;
            if (op == 3'b110) m_stg[1] = d;
            for (int c = 0; c < 2; c++) begin m_code[c] = m_stg[c]; m_sl[c] = 1'b0; end
         end
         3'b011: for (int c = 0; c < 2; c++) begin m_code[c] = d; m_sl[c] = 1'b0; end
         3'b111: if (sd_enable) begin m_sl[0] = 1'b1; m_sl[1] = 1'b1; end
         default: case (sub)
            3'b001: begin m_code[0] = m_stg[0]; m_sl[0] = 1'b0; end
            3'b101: begin m_code[1] = m_stg[1]; m_sl[1] = 1'b0; end
            3'b110: if (sd_enable) m_sl[0] = 1'b1;
            3'b111: if (sd_enable) m_sl[1] = 1'b1;
            3'b010: m_pin = 1'b0;
            3'b011: m_pin = 1'b1;
            default: ;
         endcase
      endcase
   endfunction

   // monitor: pops expected state and compares with the ports
   initial begin
      forever begin
         @(mon_ev);
         while (exp_q.size() > 0) begin
            logic [28:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({t, " code_a"}, 32'(code_a), 32'(e[28:16]));
            chk({t, " code_b"}, 32'(code_b), 32'(e[15:3]));
            chk({t, " sleep"}, {30'b0, sleep_a, sleep_b}, {30'b0, e[2:1]});
            chk({t, " user_out"}, 32'(user_out), 32'(e[0]));
         end
      end
   end

   // mode: 0 no sdo check, 1 falling launch, 2 rising launch
   task automatic shift_bits(logic [31:0] bits, int n, int mode);
      for (int k = 1; k <= n; k++) begin
         sdi = bits[n-k];
         repeat (4) @(negedge clk);
         sck = 1'b1;
         repeat (4) @(negedge clk);
         if (mode != 0 && k >= 17)
            chk("R10 sdo after rise", 32'(sdo),
                32'(bits[n-1-(mode == 2 ? k-16 : k-17)]));
         sck = 1'b0;
         repeat (4) @(negedge clk);
         if (mode != 0 && k >= 16)
            chk("R10 sdo after fall", 32'(sdo), 32'(bits[n-1-(k-16)]));
      end
   endtask

   task automatic frame(logic [31:0] bits, int n, int mode, string tag);
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      shift_bits(bits, n, mode);
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
      model_apply(bits[15:0]);
      exp_q.push_back({m_code[0], m_code[1], m_sl[0], m_sl[1], m_pin});
      tag_q.push_back(tag);
      -> mon_ev;
      repeat (2) @(negedge clk);
   endtask

   task automatic word(logic [15:0] w, string tag);
      frame({16'h0, w}, 16, 0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; clr_n = 1'b1; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; sd_enable = 1'b0;
      model_reset();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R11 reset code_a", 32'(code_a), 0);
      chk("R11 reset code_b", 32'(code_b), 0);
      chk("R11 reset sleep/pin/sdo", {29'b0, sleep_a, sleep_b, user_out}, 0);

      word(16'h2123, "R2 stage A");
      word(16'hBABC, "R2 stage B");
      word(16'h8000, "R5 copy both");
      word(16'h4055, "R3 stage A and copy");
      word(16'hCF0F, "R3 stage B and copy");
      word(16'h3111, "R2 stage A again");
      word(16'h0400, "R5 copy A only");
      word(16'hA222, "R2 stage B again");
      word(16'h1400, "R5 copy B only");
      word(16'h7FFF, "R4 direct both");
      word(16'h8000, "R4 staging untouched");

      word(16'hE000, "R7 nap both blocked");
      word(16'h1800, "R7 nap A blocked");
      sd_enable = 1'b1;
      word(16'hE000, "R6 nap both");
      @(negedge clk);
      sd_enable = 1'b0;
      #1;
      m_sl[0] = 1'b0; m_sl[1] = 1'b0;
      chk("R7 async wake", {30'b0, sleep_a, sleep_b}, 0);
      chk("R7 wake keeps code_a", 32'(code_a), 32'(m_code[0]));
      repeat (3) @(negedge clk);
      sd_enable = 1'b1;
      repeat (4) @(negedge clk);
      word(16'h1800, "R6 nap A");
      word(16'h2333, "R8 stage while asleep");
      word(16'h0400, "R8 copy wakes A");
      word(16'h1C00, "R6 nap B");
      word(16'h6444, "R8 direct wakes B");

      word(16'h0C00, "R9 pin high");
      word(16'h0800, "R9 pin low");
      word(16'h0C00, "R9 pin high again");

      word(16'h0000, "R12 no-op");
      shift_bits({16'h0, 16'h4ABC}, 16, 0);
      frame(32'h0, 0, 0, "R12 clocks with select high ignored");

      frame({16'hB38E, 16'h2AAA}, 32, 1, "R10 falling launch");
      word(16'h1200, "R10 select rising");
      frame({16'h6C39, 16'h2555}, 32, 2, "R10 rising launch");

      @(negedge clk);
      clr_n = 1'b0;
      #1;
      chk("R11 clear code_a", 32'(code_a), 0);
      chk("R11 clear code_b", 32'(code_b), 0);
      chk("R11 clear pin", 32'(user_out), 0);
      repeat (3) @(negedge clk);
      clr_n = 1'b1;
      model_reset();
      repeat (4) @(negedge clk);
      word(16'h8000, "R11 staging cleared");
      frame({16'hD2B4, 16'h0000}, 32, 1, "R11 falling launch restored");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule